// File: doc/BRIEF.md
# Serial Channel Loopback Router

This block sits between a synchronous serial controller and the cable transceivers of one channel. It routes the controller's transmit clock, transmit data and request-to-send line out to the cable pins. It routes the cable's receive clock, receive data and clear-to-send back to the controller. A two-bit mode input selects one of three kinds of operation. In normal operation the receive side listens to the cable. In external loopback the receive side listens to the pins the channel is itself driving, so the signals make a full trip through the transceivers. In internal loopback the transmit signals return to the receive side inside the block, and the transceivers take no part in that path.

A terminal-side/equipment-side select bit picks which pin of each pair transmits and which one receives. Every cable pin has its own two-bit source field, so an unused pin can be driven to a fixed level or released to act as an input. A synchronized copy of every cable input is returned as a status word. The status word always shows what the transceivers see, even while internal loopback is active.

Top module: `serial_loop_router`

## Requirements
- R1: Cable pins come in pairs, one pair per line: pin 2k is side A and pin 2k+1 is side B. Line 0 carries the clock, line 1 the data and line 2 RTS/CTS. With the side select at 0 (terminal side), side A pins transmit and side B pins receive.
- R2: With the side select at 1 (equipment side), the roles swap: side B pins transmit and side A pins receive.
- R3: Mode code 2'b00 is normal operation. Mode code 2'b11 behaves exactly like 2'b00. In both, receive clock, data and CTS come from the receive-role pin of lines 0, 1 and 2.
- R4: In mode 2'b01 (external loopback), receive clock, data and CTS are read from the pad inputs of the transmit-role pins.
- R5: In mode 2'b10 (internal loopback), receive clock, data and CTS equal transmit clock, data and RTS. This holds for either side select and whatever the transceiver enable.
- R6: In internal loopback with the transceivers enabled, the transmit-role pins keep driving the transmit signals.
- R7: While the transceiver enable is 0, every pad output enable is 0. In normal and external loopback modes the receive outputs are then 0.
- R8: Pin p uses source field bits [2p+1:2p]. The field values are: 00 = channel function (drive only if the pin has the transmit role), 01 = drive low, 10 = drive high, 11 = input only. The pad value is 1 for 10, the transmit signal of the pin's line for 00, and 0 otherwise. An enable is only granted while the transceivers are enabled.
- R9: The status word equals the pad inputs delayed by two clock edges. It is 0 during reset. It never reflects internally looped signals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status synchronizer |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_clk_i | input | 1 | Controller transmit clock |
| tx_dat_i | input | 1 | Controller transmit data |
| rts_i | input | 1 | Controller request-to-send |
| dce_side_i | input | 1 | Side select: 0 side A transmits, 1 side B transmits |
| xcvr_en_i | input | 1 | Transceiver enable |
| loop_mode_i | input | 2 | Loopback mode code |
| pin_src_i | input | 12 | Per-pin source fields, two bits per pin |
| pad_in_i | input | 6 | Cable pin levels from the transceivers |
| rx_clk_o | output | 1 | Receive clock to controller |
| rx_dat_o | output | 1 | Receive data to controller |
| cts_o | output | 1 | Clear-to-send to controller |
| pad_out_o | output | 6 | Drive level per cable pin |
| pad_oe_o | output | 6 | Output enable per cable pin |
| pin_status_o | output | 6 | Synchronized cable input levels |

## Verification
Most of the block is combinational, so a wrong side select, a swapped pin pair or a bad mode decode appears at the receive outputs and pad enables within the same cycle. The bench drives distinct transmit and pad patterns so that each source can be told apart. A fault in the synchronizer shows as a status word one cycle early or late after a pad change. Leaking looped data into status shows as a status word that follows the transmit inputs instead of the pads.

// File: rtl/slr_pkg.sv
package slr_pkg;
  typedef enum logic [1:0] {
    LM_NORMAL = 2'b00,
    LM_EXT    = 2'b01,
    LM_INT    = 2'b10,
    LM_RSVD   = 2'b11
  } loop_mode_e;

  typedef enum logic [1:0] {
    SRC_FUNC = 2'b00,
    SRC_LOW  = 2'b01,
    SRC_HIGH = 2'b10,
    SRC_HIZ  = 2'b11
  } pin_src_e;

  // pin index that transmits for a line on the chosen side
  function automatic int tx_pin_idx(input int line, input logic dce);
    return 2 * line + (dce ? 1 : 0);
  endfunction

  // pin index that receives for a line on the chosen side
  function automatic int rx_pin_idx(input int line, input logic dce);
    return 2 * line + (dce ? 0 : 1);
  endfunction
endpackage

// File: rtl/slr_pad_cell.sv
module slr_pad_cell
  import slr_pkg::*;
(
  input  logic       en,
  input  logic       tx_role,
  input  logic       func_val,
  input  logic [1:0] src,
  output logic       pad_out,
  output logic       pad_oe
);
  always_comb begin
    unique case (pin_src_e'(src))
      SRC_FUNC: begin pad_out = func_val; pad_oe = en & tx_role; end
      SRC_LOW:  begin pad_out = 1'b0;     pad_oe = en;           end
      SRC_HIGH: begin pad_out = 1'b1;     pad_oe = en;           end
      default:  begin pad_out = 1'b0;     pad_oe = 1'b0;         end
    endcase
  end
endmodule

// File: rtl/slr_rx_select.sv
module slr_rx_select
  import slr_pkg::*;
#(
  parameter int N_LINES = 3,
  localparam int N_PINS = 2 * N_LINES
) (
  input  logic [1:0]         mode,
  input  logic               en,
  input  logic               dce,
  input  logic [N_LINES-1:0] tx_vec,
  input  logic [N_PINS-1:0]  pad_in,
  output logic [N_LINES-1:0] rx_vec
);
  for (genvar k = 0; k < N_LINES; k++) begin : g_line
    logic side_a, side_b, from_tx_pin, from_rx_pin;
    assign side_a      = pad_in[2*k];
    assign side_b      = pad_in[2*k+1];
    assign from_tx_pin = dce ? side_b : side_a;
    assign from_rx_pin = dce ? side_a : side_b;
    always_comb begin
      unique case (loop_mode_e'(mode))
        LM_INT:  rx_vec[k] = tx_vec[k];
        LM_EXT:  rx_vec[k] = en & from_tx_pin;
        default: rx_vec[k] = en & from_rx_pin;
      endcase
    end
  end
endmodule

// File: rtl/slr_sync.sv
module slr_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] nxt;
    if (s == 0) begin : g_first
      assign nxt = d;
    end else begin : g_next
      assign nxt = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= nxt;
    end
  end

  assign q = stage_q[STAGES-1];

  // R9
  sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q[STAGES-1] == $past(stage_q[STAGES-2])) || $past(!rst_n))
    else $error("sync chain did not shift");
endmodule

// File: rtl/serial_loop_router.sv
module serial_loop_router
  import slr_pkg::*;
#(
  parameter int N_LINES     = 3,
  parameter int SYNC_STAGES = 2,
  localparam int N_PINS     = 2 * N_LINES,
  localparam int SRC_W      = 2 * N_PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_clk_i,
  input  logic              tx_dat_i,
  input  logic              rts_i,
  input  logic              dce_side_i,
  input  logic              xcvr_en_i,
  input  logic [1:0]        loop_mode_i,
  input  logic [SRC_W-1:0]  pin_src_i,
  input  logic [N_PINS-1:0] pad_in_i,
  output logic              rx_clk_o,
  output logic              rx_dat_o,
  output logic              cts_o,
  output logic [N_PINS-1:0] pad_out_o,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic [N_PINS-1:0] pin_status_o
);
  logic [N_LINES-1:0] tx_vec, rx_vec;
  logic [N_PINS-1:0]  tx_role;

  always_comb begin
    tx_vec = '0;
    tx_vec[0] = tx_clk_i;
    tx_vec[1] = tx_dat_i;
    if (N_LINES > 2) tx_vec[N_LINES-1] = rts_i;
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    assign tx_role[p] = ((p % 2) == 1) == dce_side_i;
    slr_pad_cell u_cell (
      .en      (xcvr_en_i),
      .tx_role (tx_role[p]),
      .func_val(tx_vec[p/2]),
      .src     (pin_src_i[2*p +: 2]),
      .pad_out (pad_out_o[p]),
      .pad_oe  (pad_oe_o[p])
    );

    // R8
    forced_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xcvr_en_i && pin_src_i[2*p +: 2] == SRC_HIGH) |-> (pad_oe_o[p] && pad_out_o[p]))
      else $error("forced-high pin not driven");
  end

  slr_rx_select #(.N_LINES(N_LINES)) u_rx (
    .mode  (loop_mode_i),
    .en    (xcvr_en_i),
    .dce   (dce_side_i),
    .tx_vec(tx_vec),
    .pad_in(pad_in_i),
    .rx_vec(rx_vec)
  );

  assign rx_clk_o = rx_vec[0];
  assign rx_dat_o = rx_vec[1];
  assign cts_o    = rx_vec[N_LINES-1];

  slr_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in_i),
    .q    (pin_status_o)
  );

  // cycles since reset, saturating, used only to qualify the latency check
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R7
  no_oe_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xcvr_en_i |-> (pad_oe_o == '0))
    else $error("pad enabled while transceivers off");

  // R5
  int_loop_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_mode_i == LM_INT) |-> ({cts_o, rx_dat_o, rx_clk_o} == {rts_i, tx_dat_i, tx_clk_i}))
    else $error("internal loop mismatch");

  // R4
  ext_loop_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xcvr_en_i && loop_mode_i == LM_EXT) |-> (rx_dat_o == pad_in_i[tx_pin_idx(1, dce_side_i)]))
    else $error("external loop data not from transmit pin");

  // R6
  int_loop_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xcvr_en_i && loop_mode_i == LM_INT && pin_src_i[2*tx_pin_idx(1, dce_side_i) +: 2] == SRC_FUNC)
    |-> (pad_oe_o[tx_pin_idx(1, dce_side_i)] && pad_out_o[tx_pin_idx(1, dce_side_i)] == tx_dat_i))
    else $error("transmit data not on pin during internal loop");

  // R9
  status_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && SYNC_STAGES == 2) |-> (pin_status_o == $past(pad_in_i, 2)))
    else $error("status latency wrong");
endmodule

// File: tb/sim_serial_loop_router.sv
module sim_serial_loop_router;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        tx_clk, tx_dat, rts, dce, en;
  logic [1:0]  mode;
  logic [11:0] src;
  logic [5:0]  pad_in;
  logic        rx_clk, rx_dat, cts;
  logic [5:0]  pad_out, pad_oe, status;

  int nrun = 0, nfail = 0;
  bit done = 0;

  serial_loop_router u0 (
    .clk(clk), .rst_n(rst_n), .tx_clk_i(tx_clk), .tx_dat_i(tx_dat), .rts_i(rts),
    .dce_side_i(dce), .xcvr_en_i(en), .loop_mode_i(mode), .pin_src_i(src),
    .pad_in_i(pad_in), .rx_clk_o(rx_clk), .rx_dat_o(rx_dat), .cts_o(cts),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pin_status_o(status)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nrun++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent model of the routing rules
  task automatic check_routing(input string tag);
    logic [2:0] txs, rxe;
    logic [5:0] oe_e, out_e;
    txs = {rts, tx_dat, tx_clk};
    for (int p = 0; p < 6; p++) begin
      logic [1:0] f;
      logic is_tx;
      f = src[2*p +: 2];
      is_tx = (p % 2 == 0) ? !dce : dce;
      oe_e[p]  = en && (f == 2'b01 || f == 2'b10 || (f == 2'b00 && is_tx));
      out_e[p] = (f == 2'b10) ? 1'b1 : (f == 2'b00) ? txs[p/2] : 1'b0;
    end
    for (int k = 0; k < 3; k++) begin
      if (mode == 2'b10)      rxe[k] = txs[k];
      else if (!en)           rxe[k] = 1'b0;
      else if (mode == 2'b01) rxe[k] = dce ? pad_in[2*k+1] : pad_in[2*k];
      else                    rxe[k] = dce ? pad_in[2*k]   : pad_in[2*k+1];
    end
    chk({tag, " oe"},  {2'b0, pad_oe},  {2'b0, oe_e});
    chk({tag, " out"}, {2'b0, pad_out}, {2'b0, out_e});
    chk({tag, " rx"},  {5'b0, cts, rx_dat, rx_clk}, {5'b0, rxe});
  endtask

  task automatic drive(input logic [2:0] t, input logic d, input logic e,
                       input logic [1:0] m, input logic [11:0] s, input logic [5:0] pi);
    @(negedge clk);
    {rts, tx_dat, tx_clk} = t;
    dce = d; en = e; mode = m; src = s; pad_in = pi;
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    drive(3'b111, 1'b0, 1'b0, 2'b00, 12'h000, 6'h3F);
    repeat (3) @(posedge clk);
    #1;
    chk("R9 status held 0 in reset", {2'b0, status}, 8'h00);
    chk("R7 no enable in reset", {2'b0, pad_oe}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_dte;
    drive(3'b101, 1'b0, 1'b1, 2'b00, 12'h000, 6'b101010);
    chk("R1 side A enables", {2'b0, pad_oe}, 8'b0001_0101);
    chk("R1 rx from side B", {5'b0, cts, rx_dat, rx_clk}, 8'b111);
    check_routing("R1 dte");
    drive(3'b010, 1'b0, 1'b1, 2'b00, 12'h000, 6'b000110);
    check_routing("R1 dte pattern2");
  endtask

  task automatic t_dce;
    drive(3'b101, 1'b1, 1'b1, 2'b00, 12'h000, 6'b010101);
    chk("R2 side B enables", {2'b0, pad_oe}, 8'b0010_1010);
    chk("R2 side B values", {2'b0, pad_out}, 8'b0011_0011);
    chk("R2 rx from side A", {5'b0, cts, rx_dat, rx_clk}, 8'b111);
    check_routing("R2 dce");
  endtask

  task automatic t_mode11;
    drive(3'b011, 1'b0, 1'b1, 2'b11, 12'h000, 6'b100010);
    chk("R3 code 11 as normal", {5'b0, cts, rx_dat, rx_clk}, 8'b101);
    check_routing("R3 code11");
    drive(3'b011, 1'b1, 1'b1, 2'b00, 12'h000, 6'b100010);
    check_routing("R3 normal dce");
  endtask

  task automatic t_ext;
    drive(3'b000, 1'b0, 1'b1, 2'b01, 12'h000, 6'b010101);
    chk("R4 ext rx from tx pins", {5'b0, cts, rx_dat, rx_clk}, 8'b111);
    check_routing("R4 ext dte");
    drive(3'b000, 1'b1, 1'b1, 2'b01, 12'h000, 6'b100001);
    chk("R4 ext dce", {5'b0, cts, rx_dat, rx_clk}, 8'b100);
  endtask

  task automatic t_int;
    drive(3'b110, 1'b0, 1'b1, 2'b10, 12'h000, 6'b000000);
    chk("R5 int rx equals tx", {5'b0, cts, rx_dat, rx_clk}, 8'b110);
    chk("R6 data pin still driven", {6'b0, pad_oe[2], pad_out[2]}, 8'b11);
    check_routing("R6 int dte");
    drive(3'b011, 1'b1, 1'b0, 2'b10, 12'h000, 6'b111111);
    chk("R5 int without xcvr", {5'b0, cts, rx_dat, rx_clk}, 8'b011);
    check_routing("R5 int dce off");
  endtask

  task automatic t_off;
    drive(3'b111, 1'b0, 1'b0, 2'b00, 12'h000, 6'h3F);
    chk("R7 enables off", {2'b0, pad_oe}, 8'h00);
    chk("R7 rx zero normal", {5'b0, cts, rx_dat, rx_clk}, 8'h00);
    drive(3'b111, 1'b0, 1'b0, 2'b01, 12'h999, 6'h3F);
    chk("R7 rx zero ext", {5'b0, cts, rx_dat, rx_clk}, 8'h00);
    chk("R7 forced pins off", {2'b0, pad_oe}, 8'h00);
  endtask

  task automatic t_gpio;
    // pin1 high, pin3 low, pin0 input-only, others function
    drive(3'b111, 1'b0, 1'b1, 2'b00, 12'b00_00_01_00_10_11, 6'b000000);
    chk("R8 pin1 forced high", {6'b0, pad_oe[1], pad_out[1]}, 8'b11);
    chk("R8 pin3 forced low", {6'b0, pad_oe[3], pad_out[3]}, 8'b10);
    chk("R8 pin0 released", {7'b0, pad_oe[0]}, 8'b0);
    check_routing("R8 gpio");
  endtask

  task automatic t_status;
    drive(3'b000, 1'b0, 1'b1, 2'b00, 12'h000, 6'b000000);
    repeat (3) @(posedge clk);
    drive(3'b000, 1'b0, 1'b1, 2'b00, 12'h000, 6'b101101);
    @(posedge clk); #1;
    chk("R9 status not after one edge", {2'b0, status}, 8'h00);
    @(posedge clk); #1;
    chk("R9 status after two edges", {2'b0, status}, 8'b0010_1101);
    // internal loop with transmit active: status follows pads only
    drive(3'b111, 1'b0, 1'b1, 2'b10, 12'h000, 6'b010010);
    repeat (2) @(posedge clk); #1;
    chk("R9 status ignores internal loop", {2'b0, status}, 8'b0001_0010);
  endtask

  initial begin
    t_reset();
    t_dte();
    t_dce();
    t_mode11();
    t_ext();
    t_int();
    t_off();
    t_gpio();
    t_status();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nrun++;
      nfail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end
endmodule